// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block carries out a block register save or restore. One command names a highest register index N, a source register holding the base address, and a direction. The sequencer then visits registers N, N-1, ... down to 0. Each register costs exactly one full-word memory access, and the address rises by one word (4 bytes) per access. In the store direction it reads the register file and issues writes to memory. In the load direction it issues reads and writes each returned word into the register file.

The start address normally comes from the source register. When a prefix address is flagged as valid with the command, the prefix is used instead. With auto-increment selected, the sequencer ends the command by writing a new value into the source register. Without a prefix that value is the address just past the last word moved. With a prefix it is the prefix address itself. Memory requests use a valid/ready handshake, and only one request is outstanding at a time. Load data returns on a separate response strobe.

Top module: `blkxfer_seq`

## Requirements
- R1: A command with highest index N performs exactly N+1 word accesses, visiting registers N down to 0. In the store direction, each access carries the current content of the register being visited.
- R2: Successive accesses of one command use addresses that rise by 4 from one access to the next.
- R3: The first access uses the prefix address when `pfx_valid_i` is 1 at the start. Otherwise it uses the value of the source register, read through the base read port.
- R4: With auto-increment and no prefix, the source register is written once after the last transfer, with start address + 4*(N+1).
- R5: With auto-increment and a prefix, the source register is written once after the last transfer, with the start (prefix) address.
- R6: When storing with prefix and auto-increment, the access for the register equal to the source register carries the start address instead of that register's content.
- R7: Without auto-increment, a store command writes no register, and a load command writes only the registers it loads.
- R8: A memory request stays asserted with unchanged address and write data until `mem_ready_i` is seen high.
- R9: In a load, the current register is written in the same cycle its response arrives, with the returned word. Any base write-back follows the last load. Register writes never coincide with a memory request.
- R10: `busy_o` is high from the cycle after an accepted start until `done_o` inclusive. `done_o` is a single-cycle pulse, and `busy_o` is low the cycle after it.
- R11: A start pulse while `busy_o` is high is ignored. The running command's accesses and write-back are unchanged.
- R12: `mem_we_o` is 1 for an access in the store direction (`store_i`=1 at start, register to memory) and 0 for the load direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command start pulse, taken only when idle |
| store_i | input | 1 | 1 = registers to memory, 0 = memory to registers |
| last_idx_i | input | IDX_W | Highest register index N |
| src_idx_i | input | IDX_W | Source (base) register index |
| autoinc_i | input | 1 | Write back the source register at the end |
| pfx_valid_i | input | 1 | Prefix address supplied |
| pfx_addr_i | input | XLEN | Prefix address |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_raddr_o | output | IDX_W | Register read index for store data |
| rf_rdata_i | input | XLEN | Register read data (combinational) |
| rf_baddr_o | output | IDX_W | Register read index for the base value |
| rf_bdata_i | input | XLEN | Base register read data (combinational) |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | IDX_W | Register write index |
| rf_wdata_o | output | XLEN | Register write data |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | XLEN | Memory byte address |
| mem_wdata_o | output | XLEN | Memory write data |
| mem_ready_i | input | 1 | Memory request accepted |
| mem_rvalid_i | input | 1 | Load response valid |
| mem_rdata_i | input | XLEN | Load response data |

## Verification
The bench builds the block with its defaults: a 32-bit word and a 4-bit register index. With these values a full sweep of all sixteen registers can be tested, and the source register can be placed either inside or outside the swept range. This covers the case where the stored base is substituted and the case where a load overwrites the base before the write-back. Throttled ready and response timing hold requests across several cycles. A single-register command covers the boundary where the first access is also the last.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_RESP = 3'd2,
    ST_WB   = 3'd3,
    ST_FIN  = 3'd4
  } xfer_st_e;

endpackage

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             store_i,
  input  logic             autoinc_i,
  input  logic [IDX_W-1:0] last_idx_i,
  input  logic             mem_ready_i,
  input  logic             mem_rvalid_i,
  output xfer_st_e         state_o,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic             store_o,
  output logic             autoinc_o,
  output logic             launch_o,
  output logic             step_o,
  output logic             busy_o,
  output logic             done_o
);

  xfer_st_e         state_q, state_d;
  logic [IDX_W-1:0] cur_q;
  logic             store_q, ai_q;
  logic             cur_last, xfer_end;

  // state to enter once one word transfer completes
  function automatic xfer_st_e after_xfer(input logic last, input logic ai);
    if (!last)  return ST_REQ;
    else if (ai) return ST_WB;
    else         return ST_FIN;
  endfunction

  function automatic logic [IDX_W-1:0] dec_idx(input logic [IDX_W-1:0] idx);
    return idx - IDX_W'(1);
  endfunction

  assign cur_last = (cur_q == '0);
  assign launch_o = (state_q == ST_IDLE) && start_i;
  assign xfer_end = ((state_q == ST_REQ) && mem_ready_i && store_q) ||
                    ((state_q == ST_RESP) && mem_rvalid_i);
  assign step_o   = xfer_end && !cur_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_REQ;
      ST_REQ:  if (mem_ready_i) state_d = store_q ? after_xfer(cur_last, ai_q) : ST_RESP;
      ST_RESP: if (mem_rvalid_i) state_d = after_xfer(cur_last, ai_q);
      ST_WB:   state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      store_q <= 1'b0;
      ai_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch_o) begin
        cur_q   <= last_idx_i;
        store_q <= store_i;
        ai_q    <= autoinc_i;
      end else if (step_o) begin
        cur_q <= dec_idx(cur_q);
      end
    end
  end

  assign state_o   = state_q;
  assign cur_idx_o = cur_q;
  assign store_o   = store_q;
  assign autoinc_o = ai_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o); // R10

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(store_q) && $stable(ai_q)); // R11

  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ) && !mem_ready_i |=> (state_q == ST_REQ) && $stable(cur_q)); // R8

endmodule

// File: rtl/blkxfer_addr.sv
module blkxfer_addr #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch_i,
  input  logic            step_i,
  input  logic            pfx_valid_i,
  input  logic [XLEN-1:0] pfx_addr_i,
  input  logic [XLEN-1:0] base_val_i,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] start_o,
  output logic [XLEN-1:0] after_o
);

  localparam int WORD_BYTES = XLEN / 8;

  logic [XLEN-1:0] addr_q, start_q;

  function automatic logic [XLEN-1:0] pick_start(input logic pv,
                                                 input logic [XLEN-1:0] pa,
                                                 input logic [XLEN-1:0] base);
    return pv ? pa : base;
  endfunction

  function automatic logic [XLEN-1:0] add_word(input logic [XLEN-1:0] a);
    return a + XLEN'(WORD_BYTES);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      start_q <= '0;
    end else if (launch_i) begin
      addr_q  <= pick_start(pfx_valid_i, pfx_addr_i, base_val_i);
      start_q <= pick_start(pfx_valid_i, pfx_addr_i, base_val_i);
    end else if (step_i) begin
      addr_q <= add_word(addr_q);
    end
  end

  assign addr_o  = addr_q;
  assign start_o = start_q;
  assign after_o = add_word(addr_q);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !launch_i |=> addr_q - $past(addr_q) == XLEN'(WORD_BYTES)); // R2

  AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_i |=> $stable(start_q)); // R5

endmodule

// File: rtl/blkxfer_data.sv
module blkxfer_data
  import blkxfer_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic [IDX_W-1:0] src_idx_i,
  input  logic             pfx_valid_i,
  input  xfer_st_e         state_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic             store_i,
  input  logic             autoinc_i,
  input  logic [XLEN-1:0]  rf_rdata_i,
  input  logic [XLEN-1:0]  start_i,
  input  logic [XLEN-1:0]  after_i,
  input  logic             mem_rvalid_i,
  input  logic [XLEN-1:0]  mem_rdata_i,
  output logic [XLEN-1:0]  mem_wdata_o,
  output logic             rf_we_o,
  output logic [IDX_W-1:0] rf_waddr_o,
  output logic [XLEN-1:0]  rf_wdata_o
);

  logic [IDX_W-1:0] src_q;
  logic             pfx_q;
  logic             load_wr, base_wr;

  // word placed on the bus for one store access
  function automatic logic [XLEN-1:0] store_word(input logic pfx, input logic ai,
                                                 input logic [IDX_W-1:0] cur,
                                                 input logic [IDX_W-1:0] src,
                                                 input logic [XLEN-1:0] regval,
                                                 input logic [XLEN-1:0] start);
    if (pfx && ai && (cur == src)) return start;
    return regval;
  endfunction

  // value left in the source register after the sweep
  function automatic logic [XLEN-1:0] base_result(input logic pfx,
                                                  input logic [XLEN-1:0] start,
                                                  input logic [XLEN-1:0] after);
    return pfx ? start : after;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      pfx_q <= 1'b0;
    end else if (launch_i) begin
      src_q <= src_idx_i;
      pfx_q <= pfx_valid_i;
    end
  end

  assign load_wr = (state_i == ST_RESP) && mem_rvalid_i;
  assign base_wr = (state_i == ST_WB);

  assign mem_wdata_o = store_i ? store_word(pfx_q, autoinc_i, cur_idx_i, src_q,
                                            rf_rdata_i, start_i) : '0;

  always_comb begin
    rf_we_o    = 1'b0;
    rf_waddr_o = '0;
    rf_wdata_o = '0;
    if (load_wr) begin
      rf_we_o    = 1'b1;
      rf_waddr_o = cur_idx_i;
      rf_wdata_o = mem_rdata_i;
    end else if (base_wr) begin
      rf_we_o    = 1'b1;
      rf_waddr_o = src_q;
      rf_wdata_o = base_result(pfx_q, start_i, after_i);
    end
  end

  AST_LOAD_ONLY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |-> !store_i); // R9

  AST_WB_NEEDS_AI: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |-> autoinc_i); // R7

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             store_i,
  input  logic [IDX_W-1:0] last_idx_i,
  input  logic [IDX_W-1:0] src_idx_i,
  input  logic             autoinc_i,
  input  logic             pfx_valid_i,
  input  logic [XLEN-1:0]  pfx_addr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] rf_raddr_o,
  input  logic [XLEN-1:0]  rf_rdata_i,
  output logic [IDX_W-1:0] rf_baddr_o,
  input  logic [XLEN-1:0]  rf_bdata_i,
  output logic             rf_we_o,
  output logic [IDX_W-1:0] rf_waddr_o,
  output logic [XLEN-1:0]  rf_wdata_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic             mem_ready_i,
  input  logic             mem_rvalid_i,
  input  logic [XLEN-1:0]  mem_rdata_i
);

  xfer_st_e         state;
  logic [IDX_W-1:0] cur_idx;
  logic             store_q, ai_q, launch, step;
  logic [XLEN-1:0]  cur_addr, start_addr, after_addr;

  blkxfer_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .store_i      (store_i),
    .autoinc_i    (autoinc_i),
    .last_idx_i   (last_idx_i),
    .mem_ready_i  (mem_ready_i),
    .mem_rvalid_i (mem_rvalid_i),
    .state_o      (state),
    .cur_idx_o    (cur_idx),
    .store_o      (store_q),
    .autoinc_o    (ai_q),
    .launch_o     (launch),
    .step_o       (step),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  blkxfer_addr #(.XLEN(XLEN)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (launch),
    .step_i      (step),
    .pfx_valid_i (pfx_valid_i),
    .pfx_addr_i  (pfx_addr_i),
    .base_val_i  (rf_bdata_i),
    .addr_o      (cur_addr),
    .start_o     (start_addr),
    .after_o     (after_addr)
  );

  blkxfer_data #(.XLEN(XLEN), .IDX_W(IDX_W)) u_data (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_i     (launch),
    .src_idx_i    (src_idx_i),
    .pfx_valid_i  (pfx_valid_i),
    .state_i      (state),
    .cur_idx_i    (cur_idx),
    .store_i      (store_q),
    .autoinc_i    (ai_q),
    .rf_rdata_i   (rf_rdata_i),
    .start_i      (start_addr),
    .after_i      (after_addr),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_wdata_o  (mem_wdata_o),
    .rf_we_o      (rf_we_o),
    .rf_waddr_o   (rf_waddr_o),
    .rf_wdata_o   (rf_wdata_o)
  );

  assign rf_raddr_o = cur_idx;
  assign rf_baddr_o = src_idx_i;
  assign mem_req_o  = (state == ST_REQ);
  assign mem_we_o   = store_q;
  assign mem_addr_o = cur_addr;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)); // R8

  AST_NO_WR_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we_o && mem_req_o)); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o && !rf_we_o); // R10

  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && $past(mem_req_o) |-> $stable(mem_we_o)); // R12

endmodule

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb;
  localparam int XLEN = 32;
  localparam int IDX_W = 4;
  localparam int NREG = 1 << IDX_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, start, store, autoinc, pfx_valid;
  logic [IDX_W-1:0] last_idx, src_idx;
  logic [XLEN-1:0]  pfx_addr;
  logic             busy, done, rf_we, mem_req, mem_we;
  logic [IDX_W-1:0] rf_raddr, rf_baddr, rf_waddr;
  logic [XLEN-1:0]  rf_rdata, rf_bdata, rf_wdata, mem_addr, mem_wdata, mem_rdata;
  logic             mem_ready, mem_rvalid;

  logic [XLEN-1:0] rf [NREG];
  logic [XLEN-1:0] mem [logic [XLEN-1:0]];
  assign rf_rdata = rf[rf_raddr];
  assign rf_bdata = rf[rf_baddr];

  blkxfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .store_i(store),
    .last_idx_i(last_idx), .src_idx_i(src_idx), .autoinc_i(autoinc),
    .pfx_valid_i(pfx_valid), .pfx_addr_i(pfx_addr), .busy_o(busy), .done_o(done),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_baddr_o(rf_baddr),
    .rf_bdata_i(rf_bdata), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr),
    .rf_wdata_o(rf_wdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  typedef struct { logic [XLEN-1:0] a; logic we; logic [XLEN-1:0] d; string atag; string dtag; } macc_t;
  typedef struct { int idx; logic [XLEN-1:0] d; string tag; } rwr_t;
  macc_t mq[$];
  rwr_t  rq[$];

  int n_chk = 0, n_bad = 0, ctr = 0;
  bit pend = 0, throttle = 0, done_seen = 0;
  logic [XLEN-1:0] pend_addr;

  function automatic logic [XLEN-1:0] mem_rd(input logic [XLEN-1:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'hC3A5_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives the responder, checks before the rising edge
  task automatic tick();
    macc_t e;
    rwr_t  w;
    mem_rvalid = pend && (!throttle || (ctr % 2 == 0));
    mem_rdata  = mem_rvalid ? mem_rd(pend_addr) : '0;
    mem_ready  = throttle ? (ctr % 3 == 0) : 1'b1;
    ctr++;
    #4;
    if (mem_rvalid) pend = 0;
    if (mem_req && mem_ready) begin
      if (mq.size() == 0) chk(0, "R1 unexpected access", mem_addr, '0);
      else begin
        e = mq.pop_front();
        chk(mem_addr == e.a, e.atag, mem_addr, e.a);
        chk(mem_we == e.we, "R12 direction", 32'(mem_we), 32'(e.we));
        if (e.we) begin
          chk(mem_wdata == e.d, e.dtag, mem_wdata, e.d);
          mem[mem_addr] = mem_wdata;
        end else begin
          pend = 1;
          pend_addr = mem_addr;
        end
      end
    end
    if (rf_we) begin
      if (rq.size() == 0) chk(0, "R7 unexpected register write", 32'(rf_waddr), '0);
      else begin
        w = rq.pop_front();
        chk(int'(rf_waddr) == w.idx, {w.tag, " index"}, 32'(rf_waddr), 32'(w.idx));
        chk(rf_wdata == w.d, w.tag, rf_wdata, w.d);
        rf[rf_waddr] = rf_wdata;
      end
    end
    if (done) begin
      done_seen = 1;
      chk(mq.size() == 0 && rq.size() == 0, "R1 done with transfers left",
          32'(mq.size() + rq.size()), '0);
    end
    @(negedge clk);
  endtask

  task automatic run(input bit st, input int n, input int src, input bit ai,
                     input bit pv, input logic [XLEN-1:0] pa, input bit thr, input bit poke);
    logic [XLEN-1:0] s;
    int k;
    s = pv ? pa : rf[src];
    for (int j = 0; j <= n; j++) begin
      int i;
      macc_t e;
      i = n - j;
      e.a = s + 32'(4 * j);
      e.we = st;
      e.atag = (j == 0) ? "R3 first address" : "R2 address step";
      if (st && pv && ai && i == src) begin
        e.d = s; e.dtag = "R6 substituted base";
      end else begin
        e.d = st ? rf[i] : '0; e.dtag = "R1 store data";
      end
      mq.push_back(e);
      if (!st) rq.push_back('{i, mem_rd(e.a), "R9 load data"});
    end
    if (ai) rq.push_back('{src, pv ? s : s + 32'(4 * (n + 1)), pv ? "R5 base prefix" : "R4 base after"});
    throttle = thr;
    done_seen = 0;
    store = st; last_idx = IDX_W'(n); src_idx = IDX_W'(src);
    autoinc = ai; pfx_valid = pv; pfx_addr = pa; start = 1;
    tick();
    start = 0;
    k = 0;
    while (!done_seen && k < 400) begin
      if (k == 1) chk(busy == 1'b1, "R10 busy after start", 32'(busy), 32'd1);
      if (poke && k == 2) begin
        start = 1; store = ~st; last_idx = '1; src_idx = IDX_W'(src + 1);
        autoinc = ~ai; pfx_valid = ~pv; pfx_addr = 32'hDEAD_0000;
      end
      if (poke && k == 4) start = 0;
      tick();
      k++;
    end
    start = 0;
    if (!done_seen) chk(0, "R10 watchdog expired", 32'(k), 32'd400);
    #4;
    chk(busy == 1'b0 && done == 1'b0, "R10 idle after done", {30'd0, busy, done}, '0);
    mq.delete(); rq.delete();
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) rf[i] = 32'h1111_0000 + 32'(i * 32'h101);
    rf[2] = 32'h0000_1000; rf[9] = 32'h0000_3000; rf[5] = 32'h0000_4000; rf[3] = 32'h0000_5000;
    rst_n = 0; start = 0; store = 0; last_idx = '0; src_idx = '0; autoinc = 0;
    pfx_valid = 0; pfx_addr = '0; mem_ready = 0; mem_rvalid = 0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #4;
    chk(!busy && !done && !mem_req && !rf_we, "R10 reset state",
        {28'd0, busy, done, mem_req, rf_we}, '0);
    @(negedge clk);
    run(1, 3, 2, 0, 0, '0, 0, 0);              // R1 R7 store no writeback
    run(0, 3, 5, 1, 0, '0, 1, 0);              // R9 R4 load throttled
    run(1, 15, 4, 1, 1, 32'h0000_2000, 0, 0);  // R6 R5 full sweep
    run(0, 0, 1, 1, 1, 32'h0000_6000, 1, 0);   // R5 single word
    run(1, 7, 9, 1, 0, '0, 1, 1);              // R11 R8 poke while busy
    run(0, 5, 3, 1, 0, '0, 0, 0);              // R9 base inside loaded range
    run(0, 2, 6, 0, 1, 32'h0000_7000, 1, 1);   // R7 R11 load without writeback
    run(1, 0, 0, 1, 0, '0, 0, 0);              // R4 single store
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL R10 global watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule